// File: doc/BRIEF.md
# Tagged-Word Synchronizing Memory

This block is a small word-addressed store in which every word carries one presence tag that reads either empty or full. It gives a producer and a consumer a way to hand single words to each other without a separate lock. A synchronized store succeeds only on an empty word: it writes the data and marks the word full. A synchronized load succeeds only on a full word: it returns the data and marks the word empty. The tag is tested and changed in the same clock edge as the data access, so no other request can slip in between the test and the update. Plain loads and stores are also offered, and they never look at the tag or change it.

One request port with a valid/ready handshake feeds the block. Every request that is answered gets one response one cycle after it is accepted. A synchronized request whose tag condition is not met is handled in one of two ways, chosen per request. A non-blocking request is answered at once with a fail flag. A blocking request is taken into a single wait slot and gives no response until a later request flips the tag of its word. The wait slot frees the port, so plain or non-blocking traffic to any word, including the word being waited on, can still flow. A second blocking synchronized request sees ready low until the slot is free again.

Top module: `fe_word_store`

## Requirements
- R1: A synchronous active-high reset clears every tag to empty and every data word to zero, empties the wait slot and holds rsp_valid low.
- R2: A plain store (req_op 2'b01) writes req_wdata to the word whatever its tag is, leaves all tags unchanged, and answers with rsp_data zero.
- R3: A plain load (req_op 2'b00) returns the stored word in rsp_data whatever its tag is, and leaves all tags unchanged.
- R4: A synchronized store (req_op 2'b11) to an empty word writes the data and sets that word's tag to full. It answers with rsp_data zero and rsp_fail low.
- R5: A synchronized load (req_op 2'b10) from a full word returns the data and clears that word's tag to empty.
- R6: A synchronized request with req_nb high whose condition is not met is answered with rsp_fail high and rsp_data zero. It leaves all data and tags unchanged.
- R7: A synchronized request with req_nb low whose condition is not met is accepted into the wait slot and gives no response. It completes in the first cycle in which its word's tag allows it, doing the action of R4 or R5. Its response then comes one cycle later with rsp_waited high. In that completion cycle req_ready is low for every request.
- R8: While the wait slot is occupied, a synchronized request with req_nb low sees req_ready low. Plain requests and requests with req_nb high are accepted for any word.
- R9: Every accepted request that does not go into the wait slot gives exactly one response with rsp_valid high in the next cycle and rsp_waited low. rsp_valid is low in every cycle that follows neither such an acceptance nor a wait-slot completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_op | input | 2 | 00 plain load, 01 plain store, 10 synchronized load, 11 synchronized store |
| req_nb | input | 1 | For synchronized ops: 1 refuses at once when the tag is wrong, 0 waits |
| req_addr | input | AW (4) | Word index |
| req_wdata | input | DW (32) | Store data |
| rsp_valid | output | 1 | Response present for one cycle |
| rsp_data | output | DW (32) | Load data, zero for stores and refusals |
| rsp_fail | output | 1 | Non-blocking synchronized request refused |
| rsp_waited | output | 1 | Response belongs to the request that completed from the wait slot |

## Verification
Every cycle, the properties check the tag effects: a successful synchronized load empties its word, a successful synchronized store fills it, and plain and refused requests leave the whole tag vector alone. They also check that responses line up with accepted requests and wait-slot completions, and that reset leaves all tags empty. Whether the right data word comes back, and whether a parked request wakes in the right cycle after another request changes its tag, can only be seen from the bench scenarios. These run a reference model that tracks data, tags and the wait slot across directed hand-off sequences and random mixes of all four operations in both modes.

// File: rtl/fe_pkg.sv
package fe_pkg;

    localparam int FE_DEPTH_DEF = 16;
    localparam int FE_WIDTH_DEF = 32;

    typedef enum logic [1:0] {
        OP_LOAD   = 2'b00,
        OP_STORE  = 2'b01,
        OP_SLOAD  = 2'b10,
        OP_SSTORE = 2'b11
    } fe_op_e;

    typedef struct packed {
        logic wr_data;
        logic wr_tag;
        logic tag_val;
        logic rd_data;
    } fe_act_t;

    function automatic logic fe_is_sync(input fe_op_e op);
        return op[1];
    endfunction

    // True when the op may proceed given the current tag of its word.
    function automatic logic fe_cond_met(input fe_op_e op, input logic tag);
        case (op)
            OP_SLOAD:  return tag;
            OP_SSTORE: return !tag;
            default:   return 1'b1;
        endcase
    endfunction

    function automatic fe_act_t fe_decode(input fe_op_e op);
        fe_act_t a;
        a.wr_data = (op == OP_STORE) || (op == OP_SSTORE);
        a.wr_tag  = fe_is_sync(op);
        a.tag_val = (op == OP_SSTORE);
        a.rd_data = (op == OP_LOAD) || (op == OP_SLOAD);
        return a;
    endfunction

endpackage

// File: rtl/fe_store_array.sv
module fe_store_array #(
    parameter int DEPTH = 16,
    parameter int DW    = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             data_we,
    input  logic             tag_we,
    input  logic             tag_val,
    input  logic [AW-1:0]    wr_addr,
    input  logic [DW-1:0]    wr_data,
    input  logic [AW-1:0]    rd_addr_a,
    output logic [DW-1:0]    rd_data_a,
    input  logic [AW-1:0]    rd_addr_b,
    output logic [DW-1:0]    rd_data_b,
    output logic [DEPTH-1:0] tag_vec
);

    logic [DW-1:0]    mem [DEPTH];
    logic [DEPTH-1:0] tags;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            tags <= '0;
        end else begin
            if (data_we) mem[wr_addr] <= wr_data;
            if (tag_we)  tags[wr_addr] <= tag_val;
        end
    end

    assign rd_data_a = mem[rd_addr_a];
    assign rd_data_b = mem[rd_addr_b];
    assign tag_vec   = tags;

endmodule

// File: rtl/fe_wait_slot.sv
module fe_wait_slot
    import fe_pkg::*;
#(
    parameter int AW = 4,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          clear,
    input  fe_op_e        in_op,
    input  logic [AW-1:0] in_addr,
    input  logic [DW-1:0] in_data,
    output logic          busy,
    output fe_op_e        op,
    output logic [AW-1:0] addr,
    output logic [DW-1:0] data
);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            op   <= OP_LOAD;
            addr <= '0;
            data <= '0;
        end else if (load) begin
            busy <= 1'b1;
            op   <= in_op;
            addr <= in_addr;
            data <= in_data;
        end else if (clear) begin
            busy <= 1'b0;
        end
    end

endmodule

// File: rtl/fe_word_store.sv
module fe_word_store
    import fe_pkg::*;
#(
    parameter int DEPTH = FE_DEPTH_DEF,
    parameter int DW    = FE_WIDTH_DEF,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [1:0]    req_op,
    input  logic          req_nb,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_data,
    output logic          rsp_fail,
    output logic          rsp_waited
);

    logic [DEPTH-1:0] tag_vec;
    logic [DW-1:0]    in_rdata, slot_rdata;
    logic             slot_busy;
    fe_op_e           slot_op;
    logic [AW-1:0]    slot_addr;
    logic [DW-1:0]    slot_wdata;

    fe_op_e in_op;
    logic   slot_fire, in_ok, in_block, acc, park, refuse, act_en;
    fe_op_e        sel_op;
    logic [AW-1:0] sel_addr;
    logic [DW-1:0] sel_wdata, sel_rdata;
    fe_act_t       act;

    assign in_op     = fe_op_e'(req_op);
    assign slot_fire = slot_busy && fe_cond_met(slot_op, tag_vec[slot_addr]);
    assign in_ok     = fe_cond_met(in_op, tag_vec[req_addr]);
    assign in_block  = fe_is_sync(in_op) && !req_nb;

    // The wait slot owns the response channel when it completes.
    assign req_ready = !slot_fire && !(slot_busy && in_block);
    assign acc       = req_valid && req_ready;
    assign park      = acc && in_block && !in_ok;
    assign refuse    = acc && fe_is_sync(in_op) && req_nb && !in_ok;

    always_comb begin
        if (slot_fire) begin
            sel_op    = slot_op;
            sel_addr  = slot_addr;
            sel_wdata = slot_wdata;
            sel_rdata = slot_rdata;
            act_en    = 1'b1;
        end else begin
            sel_op    = in_op;
            sel_addr  = req_addr;
            sel_wdata = req_wdata;
            sel_rdata = in_rdata;
            act_en    = acc && in_ok;
        end
    end

    assign act = fe_decode(sel_op);

    fe_store_array #(.DEPTH(DEPTH), .DW(DW)) u_array (
        .clk       (clk),
        .rst       (rst),
        .data_we   (act_en && act.wr_data),
        .tag_we    (act_en && act.wr_tag),
        .tag_val   (act.tag_val),
        .wr_addr   (sel_addr),
        .wr_data   (sel_wdata),
        .rd_addr_a (req_addr),
        .rd_data_a (in_rdata),
        .rd_addr_b (slot_addr),
        .rd_data_b (slot_rdata),
        .tag_vec   (tag_vec)
    );

    fe_wait_slot #(.AW(AW), .DW(DW)) u_slot (
        .clk     (clk),
        .rst     (rst),
        .load    (park),
        .clear   (slot_fire),
        .in_op   (in_op),
        .in_addr (req_addr),
        .in_data (req_wdata),
        .busy    (slot_busy),
        .op      (slot_op),
        .addr    (slot_addr),
        .data    (slot_wdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid  <= 1'b0;
            rsp_data   <= '0;
            rsp_fail   <= 1'b0;
            rsp_waited <= 1'b0;
        end else begin
            rsp_valid  <= slot_fire || (acc && !park);
            rsp_data   <= (act_en && act.rd_data) ? sel_rdata : '0;
            rsp_fail   <= refuse;
            rsp_waited <= slot_fire;
        end
    end

endmodule

// File: rtl/fe_word_store_chk.sv
module fe_word_store_chk #(
    parameter int DEPTH = 16,
    parameter int AW    = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_ready,
    input logic [1:0]       req_op,
    input logic             req_nb,
    input logic [AW-1:0]    req_addr,
    input logic             rsp_valid,
    input logic             rsp_fail,
    input logic             rsp_waited,
    input logic [DEPTH-1:0] tag_vec,
    input logic             slot_busy,
    input logic             slot_fire
);

    logic acc;
    assign acc = req_valid && req_ready;

    p_reset_clears_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> tag_vec == '0);

    p_plain_keeps_tags_r2: assert property (@(posedge clk) disable iff (rst)
        acc && !req_op[1] |=> tag_vec == $past(tag_vec));

    p_sstore_fills_r4: assert property (@(posedge clk) disable iff (rst)
        acc && req_op == 2'b11 && !tag_vec[req_addr] |=> tag_vec[$past(req_addr)]);

    p_sload_empties_r5: assert property (@(posedge clk) disable iff (rst)
        acc && req_op == 2'b10 && tag_vec[req_addr] |=> !tag_vec[$past(req_addr)]);

    p_refuse_keeps_tags_r6: assert property (@(posedge clk) disable iff (rst)
        acc && req_nb && ((req_op == 2'b10 && !tag_vec[req_addr]) ||
                          (req_op == 2'b11 && tag_vec[req_addr]))
        |=> tag_vec == $past(tag_vec) && rsp_fail);

    p_fail_is_direct_r6: assert property (@(posedge clk) disable iff (rst)
        rsp_fail |-> rsp_valid && !rsp_waited);

    p_wait_completes_r7: assert property (@(posedge clk) disable iff (rst)
        slot_fire |=> rsp_valid && rsp_waited);

    p_park_holds_blocking_r8: assert property (@(posedge clk) disable iff (rst)
        slot_busy && req_valid && req_op[1] && !req_nb |-> !req_ready);

    p_rsp_has_cause_r9: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && !rsp_waited |-> $past(acc));

endmodule

bind fe_word_store fe_word_store_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_op     (req_op),
    .req_nb     (req_nb),
    .req_addr   (req_addr),
    .rsp_valid  (rsp_valid),
    .rsp_fail   (rsp_fail),
    .rsp_waited (rsp_waited),
    .tag_vec    (tag_vec),
    .slot_busy  (slot_busy),
    .slot_fire  (slot_fire)
);

// File: tb/test_fe_word_store.sv
module test_fe_word_store;

    localparam int DEPTH = 16;
    localparam int DW    = 32;
    localparam int AW    = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_op = 2'b00;
    logic          req_nb = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          rsp_valid;
    logic [DW-1:0] rsp_data;
    logic          rsp_fail;
    logic          rsp_waited;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // Reference model state
    logic [DW-1:0] m_data [DEPTH];
    logic          m_tag  [DEPTH];
    bit            s_busy;
    logic [1:0]    s_op;
    logic [AW-1:0] s_addr;
    logic [DW-1:0] s_data;

    always #10 clk = ~clk;   // 50 MHz

    fe_word_store i_fe_word_store (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_nb(req_nb), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .rsp_fail(rsp_fail), .rsp_waited(rsp_waited)
    );

    function automatic bit can_go(input logic [1:0] op, input logic tag);
        if (op == 2'b10) return tag == 1'b1;
        if (op == 2'b11) return tag == 1'b0;
        return 1'b1;
    endfunction

    function automatic string op_req(input logic [1:0] op);
        case (op)
            2'b00:   return "R3";
            2'b01:   return "R2";
            2'b10:   return "R5";
            default: return "R4";
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Apply the model: perform op on word, return read data (zero for stores).
    function automatic logic [DW-1:0] m_apply(input logic [1:0] op,
            input logic [AW-1:0] a, input logic [DW-1:0] d);
        logic [DW-1:0] r;
        r = '0;
        if (op == 2'b00 || op == 2'b10) r = m_data[a];
        if (op == 2'b01 || op == 2'b11) m_data[a] = d;
        if (op == 2'b10) m_tag[a] = 1'b0;
        if (op == 2'b11) m_tag[a] = 1'b1;
        return r;
    endfunction

    task automatic step(input bit v, input logic [1:0] op, input bit nb,
                        input logic [AW-1:0] a, input logic [DW-1:0] d);
        bit fire, exp_rdy, ev, ef, ew;
        logic [DW-1:0] ed;
        string lab;
        @(negedge clk);
        req_valid = v; req_op = op; req_nb = nb; req_addr = a; req_wdata = d;
        #1;
        fire    = s_busy && can_go(s_op, m_tag[s_addr]);
        exp_rdy = !fire && !(s_busy && op[1] && !nb);
        lab = fire ? "R7" : "R8";
        check(req_ready == exp_rdy, lab, "req_ready", 32'(req_ready), 32'(exp_rdy));
        ev = 0; ef = 0; ew = 0; ed = '0; lab = "R9";
        if (fire) begin
            ev = 1; ew = 1; lab = "R7";
            ed = m_apply(s_op, s_addr, s_data);
            s_busy = 0;
        end else if (v && exp_rdy) begin
            if (op[1] && !can_go(op, m_tag[a])) begin
                if (nb) begin
                    ev = 1; ef = 1; lab = "R6";
                end else begin
                    s_busy = 1; s_op = op; s_addr = a; s_data = d; lab = "R7";
                end
            end else begin
                ev = 1; lab = op_req(op);
                ed = m_apply(op, a, d);
            end
        end
        @(posedge clk);
        #1;
        check(rsp_valid == ev, "R9", "rsp_valid", 32'(rsp_valid), 32'(ev));
        if (ev) begin
            check(rsp_data == ed, lab, "rsp_data", rsp_data, ed);
            check(rsp_fail == ef, "R6", "rsp_fail", 32'(rsp_fail), 32'(ef));
            check(rsp_waited == ew, "R7", "rsp_waited", 32'(rsp_waited), 32'(ew));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0F0E));
        for (int i = 0; i < DEPTH; i++) begin
            m_data[i] = '0;
            m_tag[i]  = 1'b0;
        end
        s_busy = 0; s_op = 2'b00; s_addr = '0; s_data = '0;

        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        req_valid = 1'b1; req_op = 2'b10; req_nb = 1'b0;
        #1;
        check(rsp_valid == 1'b0, "R1", "rsp_valid after reset", 32'(rsp_valid), 0);
        check(req_ready == 1'b1, "R1", "req_ready after reset", 32'(req_ready), 1);
        req_valid = 1'b0;

        // R1: all words zero, all tags empty
        for (int i = 0; i < DEPTH; i++) step(1, 2'b00, 0, AW'(i), '0);
        step(1, 2'b10, 1, 4'd5, '0);
        check(rsp_fail == 1'b1, "R1", "tag empty after reset", 32'(rsp_fail), 1);

        // R2/R3: plain store then load, tag untouched
        step(1, 2'b01, 0, 4'd7, 32'hCAFE_0007);
        step(1, 2'b00, 0, 4'd7, '0);
        step(1, 2'b10, 1, 4'd7, '0);            // R6: still empty
        // R4/R5: hand-off
        step(1, 2'b11, 0, 4'd1, 32'h1111_2222);
        step(1, 2'b11, 1, 4'd1, 32'hDEAD_DEAD); // R6: full, refused
        step(1, 2'b00, 0, 4'd1, '0);            // R3: data kept
        step(1, 2'b10, 0, 4'd1, '0);            // R5
        step(1, 2'b10, 1, 4'd1, '0);            // R6: now empty

        // R7/R8: park a blocking load, traffic continues, producer wakes it
        step(1, 2'b10, 0, 4'd2, '0);
        step(1, 2'b11, 0, 4'd3, 32'h3333);      // R8: ready low
        step(1, 2'b01, 0, 4'd9, 32'h9999);      // R8: plain accepted
        step(1, 2'b10, 1, 4'd2, '0);            // R8: nb accepted, fails
        step(1, 2'b11, 1, 4'd2, 32'hABCD_0002); // fills word 2
        step(1, 2'b00, 0, 4'd0, '0);            // R7: slot fires, ready low
        step(0, 2'b00, 0, 4'd0, '0);
        step(1, 2'b10, 1, 4'd2, '0);            // emptied by waiter
        // parked blocking store woken by a synchronized load
        step(1, 2'b11, 1, 4'd4, 32'h4444);
        step(1, 2'b11, 0, 4'd4, 32'h5555);
        step(1, 2'b10, 1, 4'd4, '0);
        step(0, 2'b00, 0, 4'd0, '0);
        step(1, 2'b00, 0, 4'd4, '0);

        // Constrained random mix
        for (int n = 0; n < 4000; n++) begin
            bit v, nb;
            logic [1:0] op;
            logic [AW-1:0] a;
            v  = ($urandom % 10) < 8;
            op = 2'($urandom);
            nb = ($urandom % 10) < 7;
            a  = (($urandom % 4) == 0) ? AW'($urandom) : AW'($urandom % 4);
            step(v, op, nb, a, $urandom);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule